// File: doc/BRIEF.md
# Direct-Page Word Add Unit

This unit carries out the 16-bit add of a memory word into the register pair YA for a small 8-bit processor core. A is the low half of the pair and Y the high half. The core pulses `start` and presents an 8-bit operand byte, a page-select flag, the current A and Y values and the current status byte. The unit builds the word address inside one of two 256-byte pages and fetches the two bytes of the word in little-endian order over a synchronous read port. It then adds the word to YA and returns the new Y, A and status byte with a one-cycle `done` pulse.

The high byte is fetched from the next address inside the same page. A word that starts at the last byte of a page takes its high byte from the first byte of that page. The add takes no carry in. Half-carry reflects the carry out of bit 11 of the word sum.

Top module: `dpw_add_unit`

## Requirements
- R1: The first read strobe carries address {7'b0, page_sel, op_byte}. With `page_sel`=1 the page base is 0x0100, and with `page_sel`=0 it is 0x0000.
- R2: The second read strobe keeps bits 15:8 of the first address and carries (op_byte+1) mod 256 in bits 7:0. With page_sel=1 and op_byte=0xFF, the reads go to 0x01FF and then to 0x0100.
- R3: When `start` is accepted at a clock edge, `mem_rd` is high in the two cycles that follow. It is low in the third cycle, and `done` is high in the fourth cycle only.
- R4: The byte from the first read is bits 7:0 of the memory word and the byte from the second read is bits 15:8. At `done`, {y_out, a_out} equals ({y_in, a_in} + word) mod 65536.
- R5: Carry (status bit 0) is set exactly when the unsigned sum is 0x10000 or more. The incoming carry bit is not added.
- R6: Half-carry (status bit 3) is set exactly when the low 12 bits of YA and of the word sum to 0x1000 or more.
- R7: Overflow (status bit 6) is set exactly when both operands have the same bit 15 and the result's bit 15 differs from it.
- R8: Sign (status bit 7) equals bit 15 of the result. Zero (status bit 1) is set exactly when the 16-bit result is 0.
- R9: Status bits 5, 4 and 2 leave the unit equal to their values in `psw_in` at `start`.
- R10: `done` lasts one cycle. A `start` that arrives while a read or the add is under way is ignored and does not alter the result.
- R11: During reset `done` and `mem_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one word add |
| op_byte | input | 8 | Low address byte of the word |
| page_sel | input | 1 | Selects page 1 (base 0x0100) instead of page 0 |
| a_in | input | 8 | Current A (low half of YA) |
| y_in | input | 8 | Current Y (high half of YA) |
| psw_in | input | 8 | Current status byte |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe; data returns in the next cycle |
| mem_rdata | input | 8 | Read data |
| a_out | output | 8 | New A, valid with done |
| y_out | output | 8 | New Y, valid with done |
| psw_out | output | 8 | New status byte, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
A sequencer stuck in the wrong state shows up at once on the ports. The strobe pattern changes, or `done` falls outside the fourth cycle, and both are visible within the four-cycle window after `start`. If the high address were formed with a full 16-bit increment or with the wrong page, the second strobe would show it in the second cycle, and the page-wrap case is there to expose it. Data bytes captured in the wrong order, or a stale carry-in, appear only in the sum and flags at `done`. The operand patterns are chosen so that each flag rule can fail on its own.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;

    // status byte bit positions
    localparam int PSW_N = 7;
    localparam int PSW_V = 6;
    localparam int PSW_H = 3;
    localparam int PSW_Z = 1;
    localparam int PSW_C = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_LO   = 2'd2,
        ST_HI   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dpw_addr_gen.sv
module dpw_addr_gen #(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic [DW-1:0] opnd,
    input  logic          page,
    input  logic          hi_sel,
    output logic [AW-1:0] addr
);
    localparam int PAD_W = AW - DW - 1;

    logic [DW-1:0] low_part;

    always_comb begin
        // the increment stays inside the low byte: the page never changes
        low_part = hi_sel ? opnd + {{(DW-1){1'b0}}, 1'b1} : opnd;
        addr     = {{PAD_W{1'b0}}, page, low_part};
    end
endmodule

// File: rtl/dpw_word_adder.sv
module dpw_word_adder #(
    parameter int WW = 16,
    parameter int SW = 8
) (
    input  logic [WW-1:0] ya,
    input  logic [WW-1:0] word,
    input  logic [SW-1:0] psw_in,
    output logic [WW-1:0] sum,
    output logic [SW-1:0] psw_out
);
    import dpw_pkg::*;

    localparam int HW = WW - 4;

    logic [WW:0] wide;
    logic [HW:0] part;

    always_comb begin
        wide = {1'b0, ya} + {1'b0, word};
        part = {1'b0, ya[HW-1:0]} + {1'b0, word[HW-1:0]};
        sum  = wide[WW-1:0];

        psw_out        = psw_in;
        psw_out[PSW_C] = wide[WW];
        psw_out[PSW_H] = part[HW];
        psw_out[PSW_V] = (ya[WW-1] == word[WW-1]) && (sum[WW-1] != ya[WW-1]);
        psw_out[PSW_N] = sum[WW-1];
        psw_out[PSW_Z] = (sum == '0);
    end
endmodule

// File: rtl/dpw_add_unit.sv
module dpw_add_unit #(
    parameter int DW = dpw_pkg::BYTE_W,
    parameter int AW = dpw_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] op_byte,
    input  logic          page_sel,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] psw_in,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] a_out,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] psw_out,
    output logic          done
);
    import dpw_pkg::*;

    localparam int WW = 2 * DW;

    typedef struct packed {
        seq_state_e    state;
        logic [DW-1:0] opnd;
        logic          page;
        logic [AW-1:0] addr;
        logic          rd;
        logic [DW-1:0] lo;
        logic [WW-1:0] ya;
        logic [DW-1:0] psw;
        logic          done;
    } regs_t;

    localparam regs_t RST_VAL = '{
        state: ST_IDLE, opnd: '0, page: 1'b0, addr: '0, rd: 1'b0,
        lo: '0, ya: '0, psw: '0, done: 1'b0
    };

    regs_t r_d, r_q;

    logic [DW-1:0] gen_opnd;
    logic          gen_page;
    logic          gen_hi;
    logic [AW-1:0] gen_addr;
    logic [WW-1:0] sum_val;
    logic [DW-1:0] sum_psw;

    always_comb begin
        gen_opnd = (r_q.state == ST_IDLE) ? op_byte  : r_q.opnd;
        gen_page = (r_q.state == ST_IDLE) ? page_sel : r_q.page;
        gen_hi   = (r_q.state == ST_ADDR);
    end

    dpw_addr_gen #(.DW(DW), .AW(AW)) u_addr (
        .opnd   (gen_opnd),
        .page   (gen_page),
        .hi_sel (gen_hi),
        .addr   (gen_addr)
    );

    dpw_word_adder #(.WW(WW), .SW(DW)) u_add (
        .ya      (r_q.ya),
        .word    ({mem_rdata, r_q.lo}),
        .psw_in  (r_q.psw),
        .sum     (sum_val),
        .psw_out (sum_psw)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.rd = 1'b0;
                if (start) begin
                    r_d.opnd  = op_byte;
                    r_d.page  = page_sel;
                    r_d.ya    = {y_in, a_in};
                    r_d.psw   = psw_in;
                    r_d.addr  = gen_addr;
                    r_d.rd    = 1'b1;
                    r_d.state = ST_ADDR;
                end
            end
            ST_ADDR: begin
                r_d.addr  = gen_addr;
                r_d.rd    = 1'b1;
                r_d.state = ST_LO;
            end
            ST_LO: begin
                r_d.lo    = mem_rdata;
                r_d.rd    = 1'b0;
                r_d.state = ST_HI;
            end
            ST_HI: begin
                r_d.ya    = sum_val;
                r_d.psw   = sum_psw;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign mem_addr = r_q.addr;
    assign mem_rd   = r_q.rd;
    assign a_out    = r_q.ya[DW-1:0];
    assign y_out    = r_q.ya[WW-1:DW];
    assign psw_out  = r_q.psw;
    assign done     = r_q.done;
endmodule

// File: rtl/dpw_add_chk.sv
module dpw_add_chk #(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [DW-1:0] psw_in,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic [DW-1:0] a_out,
    input logic [DW-1:0] y_out,
    input logic [DW-1:0] psw_out,
    input logic          done
);
    logic [2:0]    slot;
    logic [DW-1:0] cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
            cap  <= '0;
        end else if (start && slot <= 3'd1) begin
            slot <= 3'd4;
            cap  <= psw_in;
        end else if (slot != 3'd0) begin
            slot <= slot - 3'd1;
        end
    end

    AST_DONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> slot == 3'd1); // R3
    AST_RD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (slot == 3'd4 || slot == 3'd3)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_HI_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |->
        (mem_addr[AW-1:DW] == $past(mem_addr[AW-1:DW]) &&
         mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]) + 1'b1)); // R2
    AST_KEEP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (psw_out[5] == cap[5] && psw_out[4] == cap[4] && psw_out[2] == cap[2])); // R9
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> psw_out[1] == ({y_out, a_out} == '0)); // R8
    AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> psw_out[7] == y_out[DW-1]); // R8
endmodule

bind dpw_add_unit dpw_add_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .psw_in   (psw_in),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .a_out    (a_out),
    .y_out    (y_out),
    .psw_out  (psw_out),
    .done     (done)
);

// File: tb/tb_dpw_add_unit.sv
module tb_dpw_add_unit;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_byte = '0;
    logic        page_sel = 1'b0;
    logic [7:0]  a_in = '0, y_in = '0, psw_in = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic [7:0]  a_out, y_out, psw_out;
    logic        done;

    always #(PERIOD/2) clk = ~clk;

    dpw_add_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_byte(op_byte),
        .page_sel(page_sel), .a_in(a_in), .y_in(y_in), .psw_in(psw_in),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .a_out(a_out), .y_out(y_out), .psw_out(psw_out), .done(done)
    );

    // memory model: registered read, one-cycle latency
    logic [7:0] mem [0:511];
    logic [7:0] mem_q = '0;
    always @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr[8:0]];
    assign mem_rdata = mem_q;

    typedef struct {
        logic [15:0] lo_a, hi_a;
        logic [15:0] res;
        logic [7:0]  psw;
        int          t0;
    } item_t;

    item_t q[$];
    int total = 0, bad = 0, cyc = 0, rd_idx = 0, dones = 0, ops = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && mem_rd) begin
            if (q.size() == 0) chk(1'b0, "R10 unexpected read", {16'h0, mem_addr}, 32'h0);
            else if (rd_idx == 0) chk(mem_addr == q[0].lo_a, "R1 low address", {16'h0, mem_addr}, {16'h0, q[0].lo_a});
            else chk(mem_addr == q[0].hi_a, "R2 high address", {16'h0, mem_addr}, {16'h0, q[0].hi_a});
            rd_idx++;
        end
        if (rst_n && done) begin
            dones++;
            if (q.size() == 0) chk(1'b0, "R10 extra done", 32'h1, 32'h0);
            else begin
                item_t it;
                it = q.pop_front();
                chk(cyc - it.t0 == 4, "R3 done cycle", cyc - it.t0, 4);
                chk(rd_idx == 2, "R3 read count", rd_idx, 2);
                chk({y_out, a_out} == it.res, "R4 YA result", {y_out, a_out}, it.res);
                chk(psw_out[0] == it.psw[0], "R5 carry", psw_out, it.psw);
                chk(psw_out[3] == it.psw[3], "R6 half-carry", psw_out, it.psw);
                chk(psw_out[6] == it.psw[6], "R7 overflow", psw_out, it.psw);
                chk(psw_out[7] == it.psw[7] && psw_out[1] == it.psw[1], "R8 sign/zero", psw_out, it.psw);
                chk(psw_out[5:4] == it.psw[5:4] && psw_out[2] == it.psw[2], "R9 kept bits", psw_out, it.psw);
            end
            rd_idx = 0;
        end
    end

    // driver: loads memory, pushes the expected item, pulses start
    task automatic run_op(input logic [7:0] op, input logic pg, input logic [15:0] ya,
                          input logic [15:0] word, input logic [7:0] psw, input bit poke_busy);
        item_t it;
        logic [16:0] wide;
        logic [12:0] part;
        it.lo_a = {7'b0, pg, op};
        it.hi_a = {7'b0, pg, op + 8'd1};
        mem[it.lo_a[8:0]] = word[7:0];
        mem[it.hi_a[8:0]] = word[15:8];
        wide = {1'b0, ya} + {1'b0, word};
        part = {1'b0, ya[11:0]} + {1'b0, word[11:0]};
        it.res = wide[15:0];
        it.psw = psw;
        it.psw[0] = wide[16];
        it.psw[3] = part[12];
        it.psw[6] = (ya[15] == word[15]) && (it.res[15] != ya[15]);
        it.psw[7] = it.res[15];
        it.psw[1] = (it.res == 16'h0);
        @(negedge clk);
        it.t0 = cyc;
        q.push_back(it);
        ops++;
        start = 1'b1; op_byte = op; page_sel = pg;
        y_in = ya[15:8]; a_in = ya[7:0]; psw_in = psw;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            // R10: start while busy, with different operands, must be ignored
            start = 1'b1; op_byte = op ^ 8'h55; page_sel = ~pg;
            y_in = 8'hAA; a_in = 8'h55; psw_in = ~psw;
            @(negedge clk);
            start = 1'b0;
        end
        op_byte = 8'h00; y_in = 8'h00; a_in = 8'h00; psw_in = 8'h00;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && mem_rd == 1'b0, "R11 reset outputs", {done, mem_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(8'h20, 1'b0, 16'h1234, 16'h0101, 8'h00, 1'b0);   // R4 plain add
        run_op(8'h40, 1'b0, 16'hFFFF, 16'h0001, 8'h00, 1'b0);   // R5 carry, R8 zero
        run_op(8'h41, 1'b1, 16'h7FFF, 16'h0001, 8'h00, 1'b0);   // R7 overflow, R6 half-carry
        run_op(8'h10, 1'b0, 16'h0FFF, 16'h0001, 8'h00, 1'b0);   // R6 half-carry from bit 11
        run_op(8'h11, 1'b0, 16'h000F, 16'h0001, 8'h00, 1'b0);   // R6 nibble carry does not set H
        run_op(8'hFF, 1'b1, 16'h0100, 16'h8002, 8'h00, 1'b0);   // R2 wrap 0x01FF -> 0x0100
        run_op(8'hFF, 1'b0, 16'h8000, 16'h8000, 8'h00, 1'b0);   // R2 wrap page 0, R7 negative overflow
        run_op(8'h30, 1'b0, 16'h0001, 16'h0002, 8'hFF, 1'b0);   // R5 carry-in ignored, R9 kept bits
        run_op(8'h31, 1'b1, 16'h2222, 16'h1111, 8'h34, 1'b1);   // R10 start while busy
        run_op(8'h32, 1'b0, 16'hABCD, 16'h5433, 8'h00, 1'b0);   // R8 zero with carry
        chk(dones == ops, "R10 done count", dones, ops);
        chk(q.size() == 0, "R3 all results seen", q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule